// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits behind a pair of 10-bit converter channels and puts their results onto two 10-bit output buses. A source hands it one sample pair (channel A and channel B) at a time over a valid/ready interface. Conversion work runs at 40 MHz. In the modes that use an 80 MHz input clock, the block therefore accepts a pair only on every second clock edge. Each accepted pair passes through a delay line that models the converter pipeline. It then leaves on the buses in one of two arrangements. In dual-bus output, channel A drives the primary bus and channel B drives the secondary bus. In single-bus output, A and B alternate on the primary bus and the secondary bus is released.

Two configuration pins choose the arrangement. `rate_sel` high with `single_bus` low is the fast dual-bus case, with an input clock of 40 MHz and a short latency. Every other combination assumes an 80 MHz input clock. A format pin optionally turns the offset-binary codes into two's complement. Offset binary puts mid-scale at 0x200 and full-scale at 0x3FF. The block also produces a latch strobe and its complement. In single-bus output the strobe level tells a receiver which channel is on the bus. Drive-enable outputs tell the pad ring when the buses and the strobe pair should be driven. They go low under output-disable or power-down.

The input interface has back-pressure: `in_ready` is low on the cycles in which no pair can be taken. A source must hold `in_valid` and the pair steady until a cycle in which `in_valid` and `in_ready` are both high. The output side has no back-pressure, and a receiver must take each word while it is on the bus. The configuration pins are expected to change only while reset is applied.

Top module: `adc_out_formatter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both data buses read 0, `strobe` is 0, `strobe_n` is 1 and `out_valid` is 0.
- R2: `in_ready` is high on every cycle when `rate_sel`=1 and `single_bus`=0. In every other configuration `in_ready` is high on the first cycle after reset and then low and high on alternate cycles. A pair is taken only on an edge where `in_valid` and `in_ready` are both high. A pair offered while `in_ready` is low never reaches the buses.
- R3: In dual-bus output, a pair taken at edge e appears on `dout_a` (channel A) and `dout_b` (channel B) just after edge e+4 when `rate_sel`=1, and just after edge e+8 when `rate_sel`=0. The buses then hold that pair until the next pair is launched.
- R4: In single-bus output (`single_bus`=1, either `rate_sel`), a pair taken at edge e puts channel A on `dout_a` just after edge e+8 and channel B on `dout_a` just after edge e+9. `bus_b_en` stays 0.
- R5: `strobe` is 1 for exactly the cycle in which a new channel-A word, or a new dual-bus pair, has just been launched, and 0 otherwise. In single-bus output, `strobe` is therefore 1 while A is on the bus and 0 while B is on the bus.
- R6: Whenever `strobe_en` is 1, `strobe_n` is the exact inverse of `strobe`.
- R7: With `twos_fmt`=1, every launched word on either bus has bit 9 inverted, so 0x200 reads 0x000, 0x3FF reads 0x1FF and 0x000 reads 0x200. With `twos_fmt`=0, words pass unchanged.
- R8: `bus_a_en`, `bus_b_en` and `strobe_en` are all 0 whenever `oe_n`=1 or `pwr_down`=1. With `oe_n`=0 and `pwr_down`=0, `bus_a_en` and `strobe_en` are 1, and `bus_b_en` is 1 exactly when `single_bus`=0.
- R9: `out_valid` is 0 after reset until the first word is launched. It rises with that first word and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (40 MHz or 80 MHz, by configuration) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | Rate select; 1 with single_bus=0 means 40 MHz input clock |
| single_bus | input | 1 | 1 selects single-bus interleaved output |
| twos_fmt | input | 1 | 1 selects two's-complement output format |
| oe_n | input | 1 | Active-low output enable for buses and strobe pair |
| pwr_down | input | 1 | Power-down; releases buses and strobe pair |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The block can take a pair on this edge |
| in_a | input | 10 | Channel A sample, offset binary |
| in_b | input | 10 | Channel B sample, offset binary |
| dout_a | output | 10 | Primary output bus |
| dout_b | output | 10 | Secondary output bus |
| bus_a_en | output | 1 | Drive enable for the primary bus |
| bus_b_en | output | 1 | Drive enable for the secondary bus |
| strobe | output | 1 | Output latch strobe |
| strobe_n | output | 1 | Complement of the latch strobe |
| strobe_en | output | 1 | Drive enable for the strobe pair |
| out_valid | output | 1 | Goes high when the first word leaves the delay line |

## Verification
Every bus result is due a fixed number of edges after the edge that took the pair. That number is 4 or 8 in dual-bus output, and 8 for channel A and 9 for channel B in single-bus output. The bench records that accepting edge and then counts falling edges: after the n-th falling edge, exactly n further rising edges have passed. It samples each bus one edge before its due time, expecting the old value, then at the due time and one edge after, so that both early and late launches show up. The drive enables follow the control pins without a register, so they are checked a fraction of a cycle after each pin change. The ready pattern is checked cycle by cycle from the first cycle after reset.

// File: rtl/aof_pkg.sv
package aof_pkg;

  // Bus arrangement, decoded from the two configuration pins.
  typedef enum logic [1:0] {
    ARR_DUAL_SLOW = 2'd0,  // 80 MHz input, one pair per two edges, two buses
    ARR_DUAL_FAST = 2'd1,  // 40 MHz input, one pair per edge, two buses
    ARR_SINGLE    = 2'd2   // 80 MHz input, A and B interleaved on one bus
  } arr_e;

  function automatic arr_e decode_arr(input logic rate_sel, input logic single_bus);
    if (single_bus)    return ARR_SINGLE;
    else if (rate_sel) return ARR_DUAL_FAST;
    else               return ARR_DUAL_SLOW;
  endfunction

endpackage

// File: rtl/aof_rate_ctrl.sv
module aof_rate_ctrl
  import aof_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  arr_e arr,
  output logic in_ready
);

  logic full_rate;
  logic phase_q;

  assign full_rate = (arr == ARR_DUAL_FAST);

  // phase_q low marks the edge on which the internal 40 MHz sample tick lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= 1'b0;
    else if (full_rate) phase_q <= 1'b0;
    else                phase_q <= ~phase_q;
  end

  assign in_ready = full_rate | ~phase_q;

endmodule

// File: rtl/aof_delay_line.sv
module aof_delay_line #(
  parameter int W     = 10,
  parameter int DEPTH = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [W-1:0]              in_a,
  input  logic [W-1:0]              in_b,
  output logic [DEPTH-1:0]          vld,
  output logic [DEPTH-1:0][W-1:0]   pa,
  output logic [DEPTH-1:0][W-1:0]   pb
);

  // Stage k holds the pair that was taken k edges ago; a bubble travels as vld=0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      pa  <= '0;
      pb  <= '0;
    end else begin
      vld[0] <= push;
      pa[0]  <= in_a;
      pb[0]  <= in_b;
      for (int k = 1; k < DEPTH; k++) begin
        vld[k] <= vld[k-1];
        pa[k]  <= pa[k-1];
        pb[k]  <= pb[k-1];
      end
    end
  end

endmodule

// File: rtl/aof_launch.sv
module aof_launch
  import aof_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  arr_e         arr,
  input  logic         twos_fmt,
  input  logic         tap_a_vld,
  input  logic [W-1:0] tap_a_a,
  input  logic [W-1:0] tap_a_b,
  input  logic         tap_b_vld,
  input  logic [W-1:0] tap_b_b,
  output logic [W-1:0] dout_a,
  output logic [W-1:0] dout_b,
  output logic         strobe,
  output logic         strobe_n,
  output logic         out_valid
);

  localparam int LANES = 3;  // A word, paired B word, late B word

  logic [LANES-1:0][W-1:0] raw;
  logic [LANES-1:0][W-1:0] fmt;
  logic                    launch_a;
  logic                    launch_b;
  logic                    single;

  assign raw[0] = tap_a_a;
  assign raw[1] = tap_a_b;
  assign raw[2] = tap_b_b;

  // Offset binary to two's complement: flip the most significant bit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fmt[g] = raw[g] ^ {twos_fmt, {(W-1){1'b0}}};
  end

  assign single   = (arr == ARR_SINGLE);
  assign launch_a = tap_a_vld;
  assign launch_b = single & tap_b_vld & ~tap_a_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_a    <= '0;
      dout_b    <= '0;
      strobe    <= 1'b0;
      strobe_n  <= 1'b1;
      out_valid <= 1'b0;
    end else begin
      strobe    <= launch_a;
      strobe_n  <= ~launch_a;
      out_valid <= out_valid | launch_a | launch_b;
      if (launch_a) begin
        dout_a <= fmt[0];
        if (!single) dout_b <= fmt[1];
      end else if (launch_b) begin
        dout_a <= fmt[2];
      end
    end
  end

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
  import aof_pkg::*;
#(
  parameter int W        = 10,
  parameter int LAT_SLOW = 8,   // edges from acceptance to launch, 80 MHz modes
  parameter int LAT_FAST = 4,   // edges from acceptance to launch, 40 MHz dual mode
  parameter int B_SKEW   = 1    // extra edges for channel B in single-bus output
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rate_sel,
  input  logic         single_bus,
  input  logic         twos_fmt,
  input  logic         oe_n,
  input  logic         pwr_down,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] dout_a,
  output logic [W-1:0] dout_b,
  output logic         bus_a_en,
  output logic         bus_b_en,
  output logic         strobe,
  output logic         strobe_n,
  output logic         strobe_en,
  output logic         out_valid
);

  localparam int DEPTH    = LAT_SLOW + B_SKEW;
  localparam int TAP_SLOW = LAT_SLOW - 1;
  localparam int TAP_FAST = LAT_FAST - 1;
  localparam int TAP_LATE = DEPTH - 1;

  arr_e                    arr;
  logic                    push;
  logic                    drive_ok;
  logic [DEPTH-1:0]        vld;
  logic [DEPTH-1:0][W-1:0] pa;
  logic [DEPTH-1:0][W-1:0] pb;
  logic                    tap_a_vld;
  logic [W-1:0]            tap_a_a;
  logic [W-1:0]            tap_a_b;

  assign arr  = decode_arr(rate_sel, single_bus);
  assign push = in_valid & in_ready;

  aof_rate_ctrl u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .arr      (arr),
    .in_ready (in_ready)
  );

  aof_delay_line #(.W(W), .DEPTH(DEPTH)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .in_a  (in_a),
    .in_b  (in_b),
    .vld   (vld),
    .pa    (pa),
    .pb    (pb)
  );

  // The channel-A tap depends on the rate; channel B uses the same tap in
  // dual-bus output and the late tap in single-bus output.
  always_comb begin
    if (arr == ARR_DUAL_FAST) begin
      tap_a_vld = vld[TAP_FAST];
      tap_a_a   = pa[TAP_FAST];
      tap_a_b   = pb[TAP_FAST];
    end else begin
      tap_a_vld = vld[TAP_SLOW];
      tap_a_a   = pa[TAP_SLOW];
      tap_a_b   = pb[TAP_SLOW];
    end
  end

  aof_launch #(.W(W)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr       (arr),
    .twos_fmt  (twos_fmt),
    .tap_a_vld (tap_a_vld),
    .tap_a_a   (tap_a_a),
    .tap_a_b   (tap_a_b),
    .tap_b_vld (vld[TAP_LATE]),
    .tap_b_b   (pb[TAP_LATE]),
    .dout_a    (dout_a),
    .dout_b    (dout_b),
    .strobe    (strobe),
    .strobe_n  (strobe_n),
    .out_valid (out_valid)
  );

  assign drive_ok  = ~oe_n & ~pwr_down;
  assign bus_a_en  = drive_ok;
  assign bus_b_en  = drive_ok & (arr != ARR_SINGLE);
  assign strobe_en = drive_ok;

endmodule

// File: rtl/aof_checker.sv
module aof_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rate_sel,
  input logic         single_bus,
  input logic         in_ready,
  input logic [W-1:0] dout_b,
  input logic         strobe,
  input logic         strobe_n,
  input logic         strobe_en,
  input logic         out_valid
);

  AST_READY_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !(rate_sel && !single_bus)) |=> (!in_ready || (rate_sel && !single_bus))); // R2

  AST_B_CHANGES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_b) |-> strobe); // R3

  AST_SINGLE_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (single_bus && strobe) |=> (!strobe || !single_bus)); // R5

  AST_STROBE_PAIR_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_en |-> (strobe_n == !strobe)); // R6

  AST_VALID_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R9

endmodule

bind adc_out_formatter aof_checker #(.W(W)) u_aof_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_sel   (rate_sel),
  .single_bus (single_bus),
  .in_ready   (in_ready),
  .dout_b     (dout_b),
  .strobe     (strobe),
  .strobe_n   (strobe_n),
  .strobe_en  (strobe_en),
  .out_valid  (out_valid)
);

// File: tb/tb_adc_out_formatter.sv
`timescale 1ns/1ps
module tb_adc_out_formatter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_sel = 1'b0, single_bus = 1'b0, twos_fmt = 1'b0;
  logic       oe_n = 1'b0, pwr_down = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_a = '0, in_b = '0;
  logic [9:0] dout_a, dout_b;
  logic       bus_a_en, bus_b_en, strobe, strobe_n, strobe_en, out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_out_formatter dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .single_bus(single_bus),
    .twos_fmt(twos_fmt), .oe_n(oe_n), .pwr_down(pwr_down),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .dout_a(dout_a), .dout_b(dout_b), .bus_a_en(bus_a_en), .bus_b_en(bus_b_en),
    .strobe(strobe), .strobe_n(strobe_n), .strobe_en(strobe_en), .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Returns at the falling edge just after the edge that took the pair.
  task automatic send_pair(input logic [9:0] a, input logic [9:0] b);
    in_a = a; in_b = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [9:0] pat_a(input int i); return 10'(32'h050 + i * 37); endfunction
  function automatic logic [9:0] pat_b(input int i); return 10'(32'h3A0 - i * 21); endfunction

  task automatic t_reset();
    rate_sel = 0; single_bus = 0; twos_fmt = 0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 dout_a in reset", dout_a, 0);
    chk("R1 strobe_n in reset", strobe_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout_b after reset", dout_b, 0);
    chk("R1 strobe after reset", strobe, 0);
    chk("R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_ready_pattern();
    rate_sel = 0; single_bus = 0;
    do_reset();
    for (int c = 0; c < 4; c++) begin
      chk("R2 half-rate ready pattern", in_ready, (c % 2 == 0) ? 1 : 0);
      @(negedge clk);
    end
    rate_sel = 1; single_bus = 0;
    do_reset();
    for (int c = 0; c < 3; c++) begin
      chk("R2 full-rate ready every cycle", in_ready, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_dual_slow();
    rate_sel = 0; single_bus = 0; twos_fmt = 0;
    do_reset();
    send_pair(10'h155, 10'h2AA);
    repeat (7) @(negedge clk);
    chk("R3 dual slow not yet at e+7", dout_a, 0);
    chk("R9 no valid before fill", out_valid, 0);
    @(negedge clk);
    chk("R3 dual slow A at e+8", dout_a, 10'h155);
    chk("R3 dual slow B at e+8", dout_b, 10'h2AA);
    chk("R5 strobe on launch", strobe, 1);
    chk("R9 valid with first word", out_valid, 1);
    @(negedge clk);
    chk("R5 strobe low next cycle", strobe, 0);
    chk("R3 dual slow A held", dout_a, 10'h155);
    chk("R9 valid stays high", out_valid, 1);
  endtask

  task automatic t_dual_fast_stream();
    rate_sel = 1; single_bus = 0; twos_fmt = 0;
    do_reset();
    in_a = pat_a(0); in_b = pat_b(0); in_valid = 1'b1;
    for (int j = 1; j <= 11; j++) begin
      @(negedge clk);
      if (j < 6) begin in_a = pat_a(j); in_b = pat_b(j); end
      else in_valid = 1'b0;
      if (j == 4) chk("R3 dual fast not yet at e+3", dout_a, 0);
      if (j >= 5 && j <= 10) begin
        chk("R3 dual fast A at e+4", dout_a, pat_a(j - 5));
        chk("R3 dual fast B at e+4", dout_b, pat_b(j - 5));
        chk("R5 strobe steady in fast stream", strobe, 1);
      end
      if (j == 11) chk("R5 strobe low after stream", strobe, 0);
    end
  endtask

  task automatic t_single();
    for (int r = 0; r < 2; r++) begin
      rate_sel = r[0]; single_bus = 1; twos_fmt = 0;
      do_reset();
      send_pair(10'h0C3, 10'h31C);
      repeat (7) @(negedge clk);
      chk("R4 single not yet at e+7", dout_a, 0);
      @(negedge clk);
      chk("R4 single A at e+8", dout_a, 10'h0C3);
      chk("R5 strobe high with A", strobe, 1);
      @(negedge clk);
      chk("R4 single B at e+9", dout_a, 10'h31C);
      chk("R5 strobe low with B", strobe, 0);
      chk("R4 secondary bus released", bus_b_en, 0);
      chk("R8 primary bus driven", bus_a_en, 1);
      @(negedge clk);
      chk("R4 single B held", dout_a, 10'h31C);
    end
  endtask

  task automatic t_twos();
    rate_sel = 0; single_bus = 0; twos_fmt = 1;
    do_reset();
    send_pair(10'h200, 10'h3FF);
    repeat (8) @(negedge clk);
    chk("R7 mid-scale to zero", dout_a, 10'h000);
    chk("R7 full-scale to max positive", dout_b, 10'h1FF);
    send_pair(10'h000, 10'h1FF);
    repeat (8) @(negedge clk);
    chk("R7 zero code to most negative", dout_a, 10'h200);
    chk("R7 B channel bit 9 flipped", dout_b, 10'h3FF);
    twos_fmt = 0;
  endtask

  task automatic t_ignore_not_ready();
    rate_sel = 0; single_bus = 0; twos_fmt = 0;
    do_reset();
    in_a = 10'h0AA; in_b = 10'h0BB; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 ready low on alternate cycle", in_ready, 0);
    in_a = 10'h111; in_b = 10'h222;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (7) @(negedge clk);
    chk("R2 taken pair launched", dout_a, 10'h0AA);
    @(negedge clk);
    chk("R2 not-ready pair has no strobe", strobe, 0);
    chk("R2 not-ready pair not on bus A", dout_a, 10'h0AA);
    chk("R2 not-ready pair not on bus B", dout_b, 10'h0BB);
  endtask

  task automatic t_enables();
    rate_sel = 0; single_bus = 0;
    do_reset();
    oe_n = 0; pwr_down = 0; #1;
    chk("R8 enabled bus A", bus_a_en, 1);
    chk("R8 enabled bus B", bus_b_en, 1);
    chk("R8 enabled strobe", strobe_en, 1);
    chk("R6 strobe_n inverse", strobe_n, !strobe);
    oe_n = 1; #1;
    chk("R8 oe_n high releases all", {bus_a_en, bus_b_en, strobe_en}, 0);
    oe_n = 0; pwr_down = 1; #1;
    chk("R8 power-down releases all", {bus_a_en, bus_b_en, strobe_en}, 0);
    pwr_down = 0;
    send_pair(10'h001, 10'h002);
    repeat (8) @(negedge clk);
    chk("R6 strobe_n low while strobe high", strobe_n, 0);
    @(negedge clk);
    chk("R6 strobe_n high while strobe low", strobe_n, 1);
  endtask

  initial begin
    t_reset();
    t_ready_pattern();
    t_dual_slow();
    t_dual_fast_stream();
    t_single();
    t_twos();
    t_ignore_not_ready();
    t_enables();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule